// File: doc/BRIEF.md
# Load Lane Extractor and Merger

This block forms the register write-back value for every load in a 32-bit little-endian core. It receives the aligned memory word returned for a load, the two low bits of the effective address, the six-bit load opcode and the present value of the destination register. It returns the 32-bit value that the register file should take. The logic is purely combinational, so it sits between the read-data capture register and the register-file write port.

The byte offset is first turned into a one-hot lane mask. Every lane choice is then an AND-OR of that mask, so no stage uses a binary multiplexer tree. Byte and halfword loads pick one lane and extend it with its sign bit or with zeros. Word loads pass the whole word through. The unaligned left and right loads take part of the memory word and fill the rest of the result from the old register contents. Any opcode that is not one of the seven loads yields zero.

Top module: `load_lane_merge`

## Requirements
- R1: For opcode 100000 (signed byte), the result is memory bits [8k+7:8k] for offset k, sign-extended from bit 7 of that byte.
- R2: For opcode 100100 (unsigned byte), the result is memory bits [8k+7:8k] for offset k, with the upper 24 bits zero.
- R3: For opcode 100001 (signed halfword), offset 0 gives memory bits [15:0] and offset 2 gives bits [31:16], each sign-extended from bit 15.
- R4: For opcode 100101 (unsigned halfword), offset 0 gives memory bits [15:0] and offset 2 gives bits [31:16], each with the upper 16 bits zero.
- R5: A halfword load (100001 or 100101) at offset 1 or 3 gives zero.
- R6: For opcode 100011 (word), the result is the whole memory word at every offset.
- R7: For opcode 100010 (left merge), offset 3 gives the whole memory word. Offset 2 gives {mem[23:0], reg[7:0]}. Offset 1 gives {mem[15:0], reg[15:0]}. Offset 0 gives {mem[7:0], reg[23:0]}.
- R8: For opcode 100110 (right merge), offset 0 gives the whole memory word. Offset 1 gives {reg[31:24], mem[31:8]}. Offset 2 gives {reg[31:16], mem[31:16]}. Offset 3 gives {reg[31:8], mem[31:24]}.
- R9: Any opcode other than the seven above gives zero. This covers the unused code 100111, which still has bit 5 set and bit 3 clear, and the store codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Opcode field of the load instruction |
| addr_lo | input | 2 | Low two bits of the effective address (byte offset) |
| mem_word | input | 32 | Aligned word read from memory, byte 0 in bits [7:0] |
| reg_old | input | 32 | Current contents of the destination register |
| wb_value | output | 32 | Value to write back to the destination register |

## Verification
The bench runs every load opcode at all four offsets, using words whose lanes differ and whose sign bits vary. A design that decoded the lane mask in reverse, or extended from the wrong bit, would give the wrong byte or flip the upper bits. The merge loads use a register value that differs from the memory word in every byte. A swap between the left and right merge directions, or an off-by-one in the fill width, therefore shows up as a wrong byte at the boundary. Odd-offset halfwords, the unused code 100111 and store opcodes are driven with nonzero data, so a design that passed a lane through for them would be caught.

// File: rtl/load_lane_merge.sv
module load_lane_merge (
  input  logic [5:0]  op_code,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] mem_word,
  input  logic [31:0] reg_old,
  output logic [31:0] wb_value
);
  localparam logic [5:0] OP_LB  = 6'b100000;
  localparam logic [5:0] OP_LBU = 6'b100100;
  localparam logic [5:0] OP_LH  = 6'b100001;
  localparam logic [5:0] OP_LHU = 6'b100101;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_LWL = 6'b100010;
  localparam logic [5:0] OP_LWR = 6'b100110;

  logic [3:0]  lane;
  logic        is_load;
  logic [7:0]  byte_pick;
  logic [15:0] half_pick;
  logic [31:0] left_val, right_val;
  logic        s_lb, s_lbu, s_lh, s_lhu, s_lw, s_lwl, s_lwr;

  assign lane = {addr_lo == 2'd3, addr_lo == 2'd2, addr_lo == 2'd1, addr_lo == 2'd0};

  assign is_load = op_code[5] & ~op_code[3];
  assign s_lb  = is_load & (op_code == OP_LB);
  assign s_lbu = is_load & (op_code == OP_LBU);
  assign s_lh  = is_load & (op_code == OP_LH);
  assign s_lhu = is_load & (op_code == OP_LHU);
  assign s_lw  = is_load & (op_code == OP_LW);
  assign s_lwl = is_load & (op_code == OP_LWL);
  assign s_lwr = is_load & (op_code == OP_LWR);

  assign byte_pick = ({8{lane[0]}} & mem_word[7:0])
                   | ({8{lane[1]}} & mem_word[15:8])
                   | ({8{lane[2]}} & mem_word[23:16])
                   | ({8{lane[3]}} & mem_word[31:24]);

  assign half_pick = ({16{lane[0]}} & mem_word[15:0])
                   | ({16{lane[2]}} & mem_word[31:16]);

  assign left_val  = ({32{lane[3]}} & mem_word)
                   | ({32{lane[2]}} & {mem_word[23:0], reg_old[7:0]})
                   | ({32{lane[1]}} & {mem_word[15:0], reg_old[15:0]})
                   | ({32{lane[0]}} & {mem_word[7:0],  reg_old[23:0]});

  assign right_val = ({32{lane[0]}} & mem_word)
                   | ({32{lane[1]}} & {reg_old[31:24], mem_word[31:8]})
                   | ({32{lane[2]}} & {reg_old[31:16], mem_word[31:16]})
                   | ({32{lane[3]}} & {reg_old[31:8],  mem_word[31:24]});

  assign wb_value = ({32{s_lb}}  & {{24{byte_pick[7]}}, byte_pick})
                  | ({32{s_lbu}} & {24'd0, byte_pick})
                  | ({32{s_lh}}  & {{16{half_pick[15]}}, half_pick})
                  | ({32{s_lhu}} & {16'd0, half_pick})
                  | ({32{s_lw}}  & mem_word)
                  | ({32{s_lwl}} & left_val)
                  | ({32{s_lwr}} & right_val);
endmodule

// File: rtl/load_lane_merge_chk.sv
module load_lane_merge_chk (
  input logic [5:0]  op_code,
  input logic [1:0]  addr_lo,
  input logic [31:0] mem_word,
  input logic [31:0] reg_old,
  input logic [31:0] wb_value
);
  logic known;
  assign known = !$isunknown({op_code, addr_lo, mem_word, reg_old});

  always_comb begin
    if (known) begin
      // R1
      lb_sign_chk: assert (op_code != 6'b100000 || wb_value[31:8] == {24{wb_value[7]}})
        else $error("lb sign fill wrong");
      // R2
      lbu_zero_chk: assert (op_code != 6'b100100 || wb_value[31:8] == 24'd0)
        else $error("lbu upper bits not zero");
      // R4
      lhu_zero_chk: assert (op_code != 6'b100101 || wb_value[31:16] == 16'd0)
        else $error("lhu upper bits not zero");
      // R5
      half_odd_chk: assert (!((op_code == 6'b100001 || op_code == 6'b100101) && addr_lo[0]) || wb_value == 32'd0)
        else $error("odd halfword not zero");
      // R6
      word_pass_chk: assert (op_code != 6'b100011 || wb_value == mem_word)
        else $error("word load mismatch");
      // R7
      left_full_chk: assert (!(op_code == 6'b100010 && addr_lo == 2'd3) || wb_value == mem_word)
        else $error("left merge full word mismatch");
      // R8
      right_full_chk: assert (!(op_code == 6'b100110 && addr_lo == 2'd0) || wb_value == mem_word)
        else $error("right merge full word mismatch");
      // R9
      non_load_chk: assert (op_code[5] && !op_code[3] && op_code != 6'b100111 || wb_value == 32'd0)
        else $error("non-load produced data");
    end
  end
endmodule

bind load_lane_merge load_lane_merge_chk u_chk (.*);

// File: tb/tb_load_lane_merge.sv
module tb_load_lane_merge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [5:0]  op_code;
  logic [1:0]  addr_lo;
  logic [31:0] mem_word;
  logic [31:0] reg_old;
  logic [31:0] wb_value;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_lane_merge dut (.op_code(op_code), .addr_lo(addr_lo), .mem_word(mem_word),
                       .reg_old(reg_old), .wb_value(wb_value));

  task automatic drive(input logic [5:0] o, input logic [1:0] a, input logic [31:0] m, input logic [31:0] r);
    {op_code, addr_lo, mem_word, reg_old} = {o, a, m, r};
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] exp);
    total++;
    if (wb_value !== exp) begin
      bad++;
      $display("FAIL %s op=%b off=%0d got=%h exp=%h", tag, op_code, addr_lo, wb_value, exp);
    end
  endtask

  task automatic t_idle;
    drive(6'd0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R9", 32'd0);
  endtask

  task automatic t_bytes(input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = 8'(m >> (8*k));
      drive(6'b100000, 2'(k), m, 32'h1234_5678);
      check("R1", {{24{b[7]}}, b});
      drive(6'b100100, 2'(k), m, 32'h1234_5678);
      check("R2", {24'd0, b});
    end
  endtask

  task automatic t_halves(input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] h;
      h = 16'(m >> (8*k));
      drive(6'b100001, 2'(k), m, 32'hCAFE_F00D);
      if (k % 2 == 1) check("R5", 32'd0); else check("R3", {{16{h[15]}}, h});
      drive(6'b100101, 2'(k), m, 32'hCAFE_F00D);
      if (k % 2 == 1) check("R5", 32'd0); else check("R4", {16'd0, h});
    end
  endtask

  task automatic t_word(input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      drive(6'b100011, 2'(k), m, ~m);
      check("R6", m);
    end
  endtask

  task automatic t_left(input logic [31:0] m, input logic [31:0] r);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] keep;
      keep = (k == 3) ? 32'd0 : (32'hFFFF_FFFF >> (8*(k+1)));
      drive(6'b100010, 2'(k), m, r);
      check("R7", (m << (8*(3-k))) | (r & keep));
    end
  endtask

  task automatic t_right(input logic [31:0] m, input logic [31:0] r);
    for (int k = 0; k < 4; k++) begin
      drive(6'b100110, 2'(k), m, r);
      check("R8", (m >> (8*k)) | (r & ~(32'hFFFF_FFFF >> (8*k))));
    end
  endtask

  task automatic t_others;
    logic [5:0] codes [6] = '{6'b100111, 6'b101011, 6'b101000, 6'b001000, 6'b000000, 6'b110000};
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 4; k++) begin
        drive(codes[i], 2'(k), 32'hDEAD_BEEF, 32'h0BAD_F00D);
        check("R9", 32'd0);
      end
    end
  endtask

  initial begin
    {op_code, addr_lo, mem_word, reg_old} = '0;
    @(negedge clk);
    t_idle();
    t_bytes(32'h80FF_7F01);
    t_bytes(32'h7A91_3CE4);
    t_halves(32'h8001_7FFE);
    t_halves(32'h1234_ABCD);
    t_word(32'hA5C3_0F96);
    t_left(32'h1122_3344, 32'hAABB_CCDD);
    t_left(32'hF0E1_D2C3, 32'h0102_0304);
    t_right(32'h1122_3344, 32'hAABB_CCDD);
    t_right(32'hF0E1_D2C3, 32'h0102_0304);
    t_others();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule